// File: doc/BRIEF.md
# Dual-Channel Serial Converter Register Front-End

This block is the digital input side of a two-channel, 12-bit, serially loaded digital-to-analog converter. A host shifts a 14-bit word into a shift register through a serial clock, a serial data line and an active-low chip select. The first two bits are a channel address and the remaining twelve are a straight-binary code, most significant bit first. An active-low load input then copies the code into one or both 12-bit channel registers. Those registers drive the two converter codes.

The design is fully synchronous to a fast system clock. All four serial pins pass through a synchronizer of configurable depth. Rising serial-clock edges are found by comparing consecutive synchronized samples. The channel registers copy a level-sensitive latch: on every system clock while the synchronized load input is low, each selected channel takes the current data field of the shift register. If the host shifts while load is low, the selected outputs follow each bit.

Top module: `dual_dac_frontend`

## Requirements
- R1: After reset, both channel codes and the shift register are 0x000. A load issued before any shifting therefore leaves both codes at 0x000.
- R2: On each rising serial-clock edge seen while chip select is low, the shift register takes the serial data bit at its low end. The first bit of a 14-bit word ends up at bit 13, which is address bit A1. The second bit ends up at bit 12, which is A0. Bits 11..0 hold the code, MSB first.
- R3: Serial-clock edges seen while chip select is high leave the shift register unchanged.
- R4: While load is high, both channel codes hold their values whatever happens on the serial pins.
- R5: With A1 = 0 (A0 ignored), a load writes the code into both channels.
- R6: With A1 = 1 and A0 = 0, a load writes channel A only, and channel B keeps its value.
- R7: With A1 = 1 and A0 = 1, a load writes channel B only, and channel A keeps its value.
- R8: While load is low, the registers are transparent. After every bit shifted in, the selected channels show the new data field, using the address bits currently held in the shift register.
- R9: Codes are passed unchanged as straight binary. For example 0x000, 0x800 and 0xFFF appear at the outputs exactly as they were sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; must run faster than four times the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, asynchronous |
| sdi | input | 1 | Serial data, valid around the rising edge of sclk |
| cs_n | input | 1 | Active-low chip select that gates shifting |
| load_n | input | 1 | Active-low load; channel registers are transparent while it is low |
| code_a | output | 12 | Channel A converter code |
| code_b | output | 12 | Channel B converter code |

## Verification
A corrupted shift register shows up at the next load as a wrong code, or as a write to the wrong channel. With load held low it shows within a few system clocks of the offending serial edge. The address decode is exposed by pairing each address with a channel whose previous value differs, so a write to the wrong channel changes a code that should have held. Edge gating and the hold behaviour are checked by shifting with chip select high, or by toggling pins with load high, and then reading both codes. Outputs settle the synchronizer depth plus two system clocks after a pin change.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
   localparam int ADDR_W = 2;

   typedef struct packed {
      logic a;
      logic b;
   } chan_sel_t;

   // A1 low: both channels; A1 high: A0 picks B (1) or A (0)
   function automatic chan_sel_t decode_addr(input logic [ADDR_W-1:0] addr);
      chan_sel_t s;
      if (!addr[1]) begin
         s.a = 1'b1;
         s.b = 1'b1;
      end else begin
         s.a = ~addr[0];
         s.b = addr[0];
      end
      return s;
   endfunction
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
   parameter int WIDTH = 4,
   parameter int STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dacfe_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chain[s] <= RST_VAL;
         else if (s == 0)
            chain[s] <= din;
         else
            chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter #(
   parameter int WORD_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_s,
   input  logic              cs_n_s,
   input  logic              sdi_s,
   output logic              rise,
   output logic [WORD_W-1:0] word
);
   if (WORD_W < 3) begin : g_bad_word
      $error("dacfe_shifter: WORD_W too small");
   end

   logic sclk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= sclk_s;
   end

   assign rise = sclk_s & ~sclk_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         word <= '0;
      else if (rise && !cs_n_s)
         word <= {word[WORD_W-2:0], sdi_s};
   end
endmodule

// File: rtl/dacfe_chan_reg.sv
module dacfe_chan_reg #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              open_en,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       q <= '0;
      else if (open_en) q <= d;
   end
endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
   import dacfe_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk,
   input  logic              sdi,
   input  logic              cs_n,
   input  logic              load_n,
   output logic [DATA_W-1:0] code_a,
   output logic [DATA_W-1:0] code_b
);
   localparam int WORD_W = DATA_W + ADDR_W;
   localparam int NCH = 2;
   localparam int PIN_W = 4;

   if (DATA_W < 1) begin : g_bad_data
      $error("dual_dac_frontend: DATA_W must be positive");
   end

   // pin vector: [3] sclk, [2] cs_n, [1] load_n, [0] sdi
   logic [PIN_W-1:0] pins_s;
   logic sclk_s, cs_n_s, load_n_s, sdi_s;

   dacfe_sync #(
      .WIDTH(PIN_W), .STAGES(SYNC_STAGES), .RST_VAL(4'b0110)
   ) u_sync (
      .clk(clk), .rst_n(rst_n),
      .din({sclk, cs_n, load_n, sdi}),
      .dout(pins_s)
   );

   assign {sclk_s, cs_n_s, load_n_s, sdi_s} = pins_s;

   logic              sclk_rise;
   logic [WORD_W-1:0] shift_word;

   dacfe_shifter #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n),
      .sclk_s(sclk_s), .cs_n_s(cs_n_s), .sdi_s(sdi_s),
      .rise(sclk_rise), .word(shift_word)
   );

   chan_sel_t   sel;
   logic [NCH-1:0] ch_pick;
   logic [DATA_W-1:0] ch_q [NCH];

   assign sel = decode_addr(shift_word[WORD_W-1 -: ADDR_W]);
   assign ch_pick = {sel.b, sel.a};

   for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
      dacfe_chan_reg #(.DATA_W(DATA_W)) u_reg (
         .clk(clk), .rst_n(rst_n),
         .open_en(~load_n_s & ch_pick[ch]),
         .d(shift_word[DATA_W-1:0]),
         .q(ch_q[ch])
      );
   end

   assign code_a = ch_q[0];
   assign code_b = ch_q[1];
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker #(
   parameter int DATA_W = 12,
   parameter int WORD_W = 14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rise,
   input logic              cs_n_s,
   input logic              load_n_s,
   input logic              sdi_s,
   input logic [WORD_W-1:0] word,
   input logic [DATA_W-1:0] code_a,
   input logic [DATA_W-1:0] code_b
);
   AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && !cs_n_s) |=> word[0] == $past(sdi_s)); // R2
   AST_SHIFT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (!rise || cs_n_s) |=> $stable(word)); // R3
   AST_HOLD_CODES: assert property (@(posedge clk) disable iff (!rst_n)
      load_n_s |=> ($stable(code_a) && $stable(code_b))); // R4
   AST_LOAD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n_s && !word[WORD_W-1]) |=>
         (code_a == $past(word[DATA_W-1:0]) && code_b == $past(word[DATA_W-1:0]))); // R5
   AST_ONLY_A: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n_s && word[WORD_W-1] && !word[WORD_W-2]) |=>
         (code_a == $past(word[DATA_W-1:0]) && $stable(code_b))); // R6
   AST_ONLY_B: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_n_s && word[WORD_W-1] && word[WORD_W-2]) |=>
         (code_b == $past(word[DATA_W-1:0]) && $stable(code_a))); // R7
endmodule

bind dual_dac_frontend dacfe_checker #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .rise(sclk_rise), .cs_n_s(cs_n_s),
   .load_n_s(load_n_s), .sdi_s(sdi_s), .word(shift_word),
   .code_a(code_a), .code_b(code_b)
);

// File: tb/dual_dac_frontend_bench.sv
module dual_dac_frontend_bench;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 12;
   localparam int SYNC = 2;
   localparam int HOLD = SYNC + 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1, load_n = 1'b1;
   logic [DW-1:0] code_a, code_b;

   int errors = 0;
   int checks = 0;
   logic [13:0] m_sr = '0;
   logic [DW-1:0] m_a = '0, m_b = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dual_dac_frontend #(.DATA_W(DW), .SYNC_STAGES(SYNC)) u_dual_dac_frontend (
      .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
      .load_n(load_n), .code_a(code_a), .code_b(code_b)
   );

   task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %03h expected %03h", tag, got, exp);
      end
   endtask

   task automatic settle();
      repeat (HOLD) @(posedge clk);
      @(negedge clk);
   endtask

   // model of the transparent latches for the current shift register
   task automatic model_load();
      if (!m_sr[13]) begin
         m_a = m_sr[11:0];
         m_b = m_sr[11:0];
      end else if (!m_sr[12]) m_a = m_sr[11:0];
      else                    m_b = m_sr[11:0];
   endtask

   task automatic check_both(input string tag);
      check({tag, " chA"}, code_a, m_a);
      check({tag, " chB"}, code_b, m_b);
   endtask

   task automatic send_bit(input logic b, input bit look);
      sdi = b;
      settle();
      sclk = 1'b1;
      settle();
      sclk = 1'b0;
      if (!cs_n) m_sr = {m_sr[12:0], b};
      if (!load_n) model_load();
      settle();
      if (look) check_both("R8 transparent shift");
   endtask

   task automatic send_word(input logic [1:0] adr, input logic [DW-1:0] code, input bit look);
      logic [13:0] w;
      w = {adr, code};
      for (int i = 13; i >= 0; i--) send_bit(w[i], look);
   endtask

   task automatic pulse_load();
      load_n = 1'b0;
      model_load();
      settle();
      load_n = 1'b1;
      settle();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      settle();
      check_both("R1 reset");
      pulse_load();
      check_both("R1 load after reset");

      // straight binary extremes, one channel at a time
      cs_n = 1'b0;
      send_word(2'b10, 12'h800, 1'b0); cs_n = 1'b1; pulse_load();
      check_both("R6 R9 midscale to A");
      cs_n = 1'b0;
      send_word(2'b11, 12'hFFF, 1'b0); cs_n = 1'b1; pulse_load();
      check_both("R7 R9 fullscale to B");
      cs_n = 1'b0;
      send_word(2'b01, 12'h000, 1'b0); cs_n = 1'b1; pulse_load();
      check_both("R5 R9 zero to both");

      // R4: pin activity with load high changes nothing
      cs_n = 1'b0;
      send_word(2'b00, 12'h3C5, 1'b0);
      check_both("R4 hold while shifting");
      cs_n = 1'b1;
      pulse_load();
      check_both("R2 R5 word landed");

      // R3: shifting with chip select high is ignored
      cs_n = 1'b0;
      send_word(2'b10, 12'h111, 1'b0); cs_n = 1'b1; pulse_load();
      send_word(2'b00, 12'hEEE, 1'b0);
      pulse_load();
      check_both("R3 gated shift");

      // R8: transparency with load low during shifting
      cs_n = 1'b0;
      load_n = 1'b0;
      send_word(2'b10, 12'hA5C, 1'b1);
      send_word(2'b11, 12'h36B, 1'b1);
      load_n = 1'b1;
      cs_n = 1'b1;
      settle();
      check_both("R8 after release");

      // sweep of codes and addresses
      for (int k = 0; k < 242; k++) begin
         logic [DW-1:0] c;
         c = 12'((k * 17) % 4096);
         if (k == 241) c = 12'hFFF;
         cs_n = 1'b0;
         send_word(2'(k), c, 1'b0);
         cs_n = 1'b1;
         pulse_load();
         check_both("R2 R5 R6 R7 R9 sweep");
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule